// File: doc/BRIEF.md
# Page Translation Unit with Associative Lookup and Table Walk

This block turns a logical address, split into a page number and an offset, into a physical address. A small set of page-to-frame entries is held in registers and searched all at once. When an entry matches, the translation is returned on the cycle after the request is accepted. When no entry matches, the block makes one read of the page table in main memory at the table base plus the page number. It then builds the physical address from the frame that comes back and stores that pair in the associative set, overwriting the entries in turn.

Before any lookup, the page number is checked against a configured table length. A page outside the table gets an error response and causes no memory read. A flush input clears every cached entry, for use when the active page table is replaced. Two counters, one for hits and one for walks, let the hit ratio be measured.

Top module: `xlat_top`

## Requirements
- R1: The page number of an accepted request is compared with every valid entry in the same cycle. On a match the response arrives with `rsp_valid` high on the cycle after acceptance, with `rsp_hit`=1 and `rsp_err`=0.
- R2: A request that matches an entry causes no pulse on `mem_req`.
- R3: An in-range request that matches no entry pulses `mem_req` for exactly one cycle, the cycle after acceptance, with `mem_addr` = table base + page number. The response comes on the cycle after `mem_rvalid`, with `rsp_hit`=0.
- R4: A request whose page number is greater than or equal to the table length gets a response on the next cycle with `rsp_err`=1 and `rsp_paddr`=0. It issues no memory read, whether or not the page is cached.
- R5: The physical address is the frame in the upper bits, followed by the unchanged offset of the request in the lowest OFF_W bits. The logical address carries the page in its upper PAGE_W bits and the offset in its lower OFF_W bits.
- R6: Each completed walk stores its page/frame pair in one entry. Entries are filled and then replaced in round-robin order from entry 0. With 4 entries, the fifth distinct walked page evicts the first. At most one entry matches any page.
- R7: One cycle of `flush` invalidates all entries, so the next request for any page walks the table.
- R8: `req_ready` is low from the cycle after a walk is started until the cycle the response is given. No request is accepted in that time.
- R9: `hit_count` rises by one with each hit response. `miss_count` rises by one with each walk response. Error responses change neither counter. Both counters are already updated in the cycle the response is valid.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req`=0, both counters are 0, no entry is valid, and the table base and table length are 0.
- R11: A cycle with `cfg_wr` high loads `cfg_base` and `cfg_len`. Requests accepted afterwards use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Loads the table base and length |
| cfg_base | input | MEM_AW | Page table base address to load |
| cfg_len | input | PAGE_W+1 | Number of table entries to load |
| flush | input | 1 | Invalidates every cached entry |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | PAGE_W+OFF_W | Logical address {page, offset} |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset} |
| rsp_err | output | 1 | Page outside the table |
| rsp_hit | output | 1 | Translation came from the associative set |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | MEM_AW | Table entry address |
| mem_rvalid | input | 1 | Table read data present |
| mem_rdata | input | FRAME_W | Frame number read from the table |
| hit_count | output | CNT_W | Hit responses since reset |
| miss_count | output | CNT_W | Walk responses since reset |

## Verification
The assertions check several properties on every cycle. The response to each accepted request must follow its path: a hit, an error or a walk start on the next cycle. A hit or an error must never raise a memory read. A read pulse must last one cycle, with the request port stalled while it is outstanding. No two entries may match at once. The counters must move only with the matching response type. Only the bench's scenarios can show the following: that the frame and offset land in the right address bits, that the read address is base plus page, that round-robin replacement evicts the oldest entry, and that flush and a new configuration take effect for later requests.

// File: rtl/xlat_pkg.sv
// Package: shared state encoding for the translation unit.
// Assumes: nothing beyond the standard language.
package xlat_pkg;
    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WALK = 1'b1
    } xlat_state_t;
endpackage

// File: rtl/xlat_cam.sv
// Fully associative page/frame store. All valid entries are compared
// against the lookup page in parallel. A write stores a pair at the
// round-robin pointer, and flush clears every valid bit in one cycle.
// Assumes: a page is only installed after it missed, so no duplicate
// appears. When flush and install meet in one cycle, flush wins.
module xlat_cam #(
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 4,
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PAGE_W-1:0]  look_page,
    output logic               look_hit,
    output logic [FRAME_W-1:0] look_frame,
    output logic [ENTRIES-1:0] look_match,
    input  logic               ins_en,
    input  logic [PAGE_W-1:0]  ins_page,
    input  logic [FRAME_W-1:0] ins_frame
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]             ent_valid;
    logic [PAGE_W-1:0]              ent_page  [ENTRIES];
    logic [FRAME_W-1:0]             ent_frame [ENTRIES];
    logic [IDX_W-1:0]               rr_ptr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Compare one entry against the lookup page.
        assign look_match[g] = ent_valid[g] && (ent_page[g] == look_page);

        // Hold one entry; clear on reset or flush, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                ent_valid[g] <= 1'b0;
                ent_page[g]  <= '0;
                ent_frame[g] <= '0;
            end else if (ins_en && rr_ptr == IDX_W'(g)) begin
                ent_valid[g] <= 1'b1;
                ent_page[g]  <= ins_page;
                ent_frame[g] <= ins_frame;
            end
        end
    end

    // Merge the frame of the (single) matching entry.
    always_comb begin
        look_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) look_frame = look_frame | ent_frame[i];
        end
    end

    assign look_hit = |look_match;

    // Advance the replacement pointer once per install, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (ins_en && !flush) begin
            rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_ctrl.sv
// Request sequencer. It range-checks the page, answers hits and errors
// on the next cycle, and otherwise starts one page-table read at
// base + page. It then waits for the data, answers, and installs the pair.
// Assumes: memory returns exactly one mem_rvalid per mem_req, at any
// later cycle.
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int PAGE_W  = 4,
    parameter int OFF_W   = 3,
    parameter int FRAME_W = 4,
    parameter int MEM_AW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MEM_AW-1:0]        tbl_base,
    input  logic [PAGE_W:0]          tbl_len,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [PAGE_W+OFF_W-1:0]  req_laddr,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic                     rsp_err,
    output logic                     rsp_hit,
    output logic                     mem_req,
    output logic [MEM_AW-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [FRAME_W-1:0]       mem_rdata,
    input  logic                     cam_hit,
    input  logic [FRAME_W-1:0]       cam_frame,
    output logic [PAGE_W-1:0]        look_page,
    output logic                     ins_en,
    output logic [PAGE_W-1:0]        ins_page,
    output logic                     inc_hit,
    output logic                     inc_miss
);
    xlat_state_t       state;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic              fire;
    logic              in_range;
    logic [OFF_W-1:0]  req_off;

    // Split the request and qualify it.
    assign look_page = req_laddr[PAGE_W+OFF_W-1:OFF_W];
    assign req_off   = req_laddr[OFF_W-1:0];
    assign req_ready = (state == XS_IDLE);
    assign fire      = req_valid && req_ready;
    assign in_range  = {1'b0, look_page} < tbl_len;

    // Install and count strobes, taken on the edge that raises the response.
    assign ins_en   = (state == XS_WALK) && mem_rvalid;
    assign ins_page = page_q;
    assign inc_hit  = fire && in_range && cam_hit;
    assign inc_miss = ins_en;

    // Sequence a request through lookup or walk and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= XS_IDLE;
            page_q    <= '0;
            off_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_err   <= 1'b0;
            rsp_hit   <= 1'b0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_req   <= 1'b0;
            case (state)
                XS_IDLE: begin
                    if (fire) begin
                        if (!in_range) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_paddr <= '0;
                        end else if (cam_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_hit   <= 1'b1;
                            rsp_paddr <= {cam_frame, req_off};
                        end else begin
                            mem_req  <= 1'b1;
                            mem_addr <= tbl_base + MEM_AW'(look_page);
                            page_q   <= look_page;
                            off_q    <= req_off;
                            state    <= XS_WALK;
                        end
                    end
                end
                XS_WALK: begin
                    if (mem_rvalid) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_hit   <= 1'b0;
                        rsp_paddr <= {mem_rdata, off_q};
                        state     <= XS_IDLE;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_stats.sv
// Hit and walk counters for hit-ratio measurement. They wrap at full scale.
// Assumes: each strobe is high for one cycle per response.
module xlat_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_hit,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    // Count responses of each kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (inc_hit)  hit_count  <= hit_count + 1'b1;
            if (inc_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_top.sv
// Page translation unit: configuration registers, associative store,
// request sequencer and statistics.
// Assumes: the configuration does not change while a walk is in flight.
module xlat_top #(
    parameter int PAGE_W  = 4,
    parameter int OFF_W   = 3,
    parameter int FRAME_W = 4,
    parameter int ENTRIES = 4,
    parameter int MEM_AW  = 8,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [MEM_AW-1:0]        cfg_base,
    input  logic [PAGE_W:0]          cfg_len,
    input  logic                     flush,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [PAGE_W+OFF_W-1:0]  req_laddr,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic                     rsp_err,
    output logic                     rsp_hit,
    output logic                     mem_req,
    output logic [MEM_AW-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [FRAME_W-1:0]       mem_rdata,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count
);
    logic [MEM_AW-1:0]  tbl_base;
    logic [PAGE_W:0]    tbl_len;
    logic [PAGE_W-1:0]  look_page;
    logic               cam_hit;
    logic [FRAME_W-1:0] cam_frame;
    logic [ENTRIES-1:0] cam_match;
    logic               ins_en;
    logic [PAGE_W-1:0]  ins_page;
    logic               inc_hit;
    logic               inc_miss;

    // Hold the table base and length written by configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base <= '0;
            tbl_len  <= '0;
        end else if (cfg_wr) begin
            tbl_base <= cfg_base;
            tbl_len  <= cfg_len;
        end
    end

    xlat_cam #(
        .PAGE_W (PAGE_W),
        .FRAME_W(FRAME_W),
        .ENTRIES(ENTRIES)
    ) i_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_page (look_page),
        .look_hit  (cam_hit),
        .look_frame(cam_frame),
        .look_match(cam_match),
        .ins_en    (ins_en),
        .ins_page  (ins_page),
        .ins_frame (mem_rdata)
    );

    xlat_ctrl #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .FRAME_W(FRAME_W),
        .MEM_AW (MEM_AW)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_base  (tbl_base),
        .tbl_len   (tbl_len),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_laddr (req_laddr),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_err   (rsp_err),
        .rsp_hit   (rsp_hit),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .cam_hit   (cam_hit),
        .cam_frame (cam_frame),
        .look_page (look_page),
        .ins_en    (ins_en),
        .ins_page  (ins_page),
        .inc_hit   (inc_hit),
        .inc_miss  (inc_miss)
    );

    xlat_stats #(
        .CNT_W(CNT_W)
    ) i_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_hit   (inc_hit),
        .inc_miss  (inc_miss),
        .hit_count (hit_count),
        .miss_count(miss_count)
    );
endmodule

// File: rtl/xlat_checker.sv
// Protocol and consistency properties for xlat_top, attached by bind.
// Assumes: it observes the top-level ports plus the lookup result and
// the configured table length.
module xlat_checker #(
    parameter int PAGE_W  = 4,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [PAGE_W-1:0]  look_page,
    input logic [PAGE_W:0]    tbl_len,
    input logic               cam_hit,
    input logic [ENTRIES-1:0] cam_match,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic               rsp_hit,
    input logic               mem_req,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count
);
    logic acc_in;
    logic acc_out;
    assign acc_in  = req_valid && req_ready && ({1'b0, look_page} < tbl_len);
    assign acc_out = req_valid && req_ready && ({1'b0, look_page} >= tbl_len);

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in && cam_hit) |=> (rsp_valid && rsp_hit && !rsp_err)); // R1
    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in && cam_hit) |=> !mem_req); // R2
    AST_MISS_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in && !cam_hit) |=> (mem_req && !rsp_valid)); // R3
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_RANGE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_out |=> (rsp_valid && rsp_err && !mem_req)); // R4
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cam_match)); // R6
    AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R8
    AST_HIT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (hit_count == CNT_W'($past(hit_count) + 1'b1))); // R9
    AST_ERR_UNCOUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(hit_count) && $stable(miss_count))); // R9
endmodule

bind xlat_top xlat_checker #(
    .PAGE_W (PAGE_W),
    .ENTRIES(ENTRIES),
    .CNT_W  (CNT_W)
) i_xlat_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .look_page (look_page),
    .tbl_len   (tbl_len),
    .cam_hit   (cam_hit),
    .cam_match (cam_match),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_hit   (rsp_hit),
    .mem_req   (mem_req),
    .hit_count (hit_count),
    .miss_count(miss_count)
);

// File: tb/test_xlat_top.sv
// Directed bench for xlat_top: one task per scenario, each checking itself.
module test_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_base = '0;
    logic [4:0]  cfg_len = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_laddr = '0;
    logic        rsp_valid;
    logic [6:0]  rsp_paddr;
    logic        rsp_err;
    logic        rsp_hit;
    logic        mem_req;
    logic [7:0]  mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [3:0]  mem_rdata = '0;
    logic [15:0] hit_count;
    logic [15:0] miss_count;

    int checks = 0;
    int fails = 0;
    int reads = 0;
    logic [7:0] last_addr = '0;
    int exp_hits = 0;
    int exp_miss = 0;

    xlat_top i_xlat_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .flush(flush), .req_valid(req_valid),
        .req_ready(req_ready), .req_laddr(req_laddr), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_err(rsp_err), .rsp_hit(rsp_hit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    always #2 clk = ~clk;

    // Page table contents: the frame stored at a table address.
    function automatic logic [3:0] tbl_frame(input logic [7:0] a);
        return 4'((a * 5) + 3);
    endfunction

    // Memory model: answers each read three cycles later, counts reads.
    int pend = 0;
    int dly = 0;
    logic [7:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend != 0) begin
            if (dly == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tbl_frame(pend_addr);
                pend = 0;
            end else begin
                dly = dly - 1;
            end
        end
        if (mem_req) begin
            pend = 1;
            dly = 2;
            pend_addr = mem_addr;
            last_addr = mem_addr;
            reads = reads + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [7:0] base, input logic [4:0] len);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_base = base; cfg_len = len;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Issue one request and collect its response and side effects.
    task automatic xlat(input logic [3:0] pg, input logic [2:0] off,
                        output logic [6:0] pa, output logic er, output logic ht,
                        output int lat, output logic stalled, output int nrd);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = reads;
        req_valid = 1'b1;
        req_laddr = {pg, off};
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        stalled = !req_ready;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
            if (!rsp_valid && req_ready) stalled = 1'b0;
        end
        pa = rsp_paddr; er = rsp_err; ht = rsp_hit;
        nrd = reads - r0;
    endtask

    // Expect a walk: read at base+page, frame from table, stall held.
    task automatic expect_walk(input logic [7:0] base, input logic [3:0] pg,
                               input logic [2:0] off, input string tag);
        logic [6:0] pa; logic er, ht, st; int lat, nrd;
        logic [6:0] exp_pa;
        logic [7:0] a;
        a = base + 8'(pg);
        exp_pa = {tbl_frame(a), off};
        xlat(pg, off, pa, er, ht, lat, st, nrd);
        exp_miss++;
        check(pa == exp_pa && !er && !ht, {tag, " R3 R5 walk result"}, {er, ht, pa}, {2'b00, exp_pa});
        check(nrd == 1 && last_addr == a, {tag, " R3 read count/address"}, {nrd[7:0], last_addr}, {8'd1, a});
        check(st && lat > 1, {tag, " R8 stall during walk"}, {st, 8'(lat)}, 1);
    endtask

    task automatic expect_hit(input logic [7:0] base, input logic [3:0] pg,
                              input logic [2:0] off, input string tag);
        logic [6:0] pa; logic er, ht, st; int lat, nrd;
        logic [6:0] exp_pa;
        exp_pa = {tbl_frame(base + 8'(pg)), off};
        xlat(pg, off, pa, er, ht, lat, st, nrd);
        exp_hits++;
        check(pa == exp_pa && ht && !er && lat == 1, {tag, " R1 R5 hit next cycle"}, {8'(lat), ht, pa}, {8'd1, 1'b1, exp_pa});
        check(nrd == 0, {tag, " R2 no read on hit"}, nrd, 0);
    endtask

    task automatic expect_err(input logic [3:0] pg, input string tag);
        logic [6:0] pa; logic er, ht, st; int lat, nrd;
        xlat(pg, 3'd0, pa, er, ht, lat, st, nrd);
        check(er && pa == 0 && lat == 1 && nrd == 0, {tag, " R4 range error"}, {er, 8'(nrd), pa}, {1'b1, 8'd0, 7'd0});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R10 reset outputs", {req_ready, rsp_valid, mem_req}, 3'b100);
        check(hit_count == 0 && miss_count == 0, "R10 reset counters", {hit_count, miss_count}, 0);
        // Length resets to 0, so every page is out of range.
        expect_err(4'd0, "R10 reset length");
    endtask

    task automatic t_miss_hit();
        configure(8'h40, 5'd12);
        expect_walk(8'h40, 4'd2, 3'd5, "R11 first walk");
        expect_hit(8'h40, 4'd2, 3'd1, "R1 repeat page");
        expect_hit(8'h40, 4'd2, 3'd7, "R5 top offset");
    endtask

    task automatic t_range();
        expect_err(4'd12, "R4 page equal length");
        expect_err(4'd15, "R4 top page");
        expect_walk(8'h40, 4'd11, 3'd0, "R4 last valid page");
        // Shrink the table: a cached page now out of range still errors.
        configure(8'h40, 5'd2);
        expect_err(4'd2, "R4 cached page out of range");
        configure(8'h40, 5'd12);
    endtask

    task automatic t_round_robin();
        // Entries hold 2, 11; fill 3, 4, then 5 evicts 2.
        expect_walk(8'h40, 4'd3, 3'd2, "R6 fill e2");
        expect_walk(8'h40, 4'd4, 3'd3, "R6 fill e3");
        expect_walk(8'h40, 4'd5, 3'd4, "R6 evict e0");
        expect_hit(8'h40, 4'd11, 3'd6, "R6 e1 kept");
        expect_hit(8'h40, 4'd3, 3'd6, "R6 e2 kept");
        expect_walk(8'h40, 4'd2, 3'd1, "R6 evicted page walks");
        expect_walk(8'h40, 4'd11, 3'd1, "R6 second eviction");
    endtask

    task automatic t_flush_cfg();
        do_flush();
        expect_walk(8'h40, 4'd3, 3'd0, "R7 walk after flush");
        expect_hit(8'h40, 4'd3, 3'd3, "R7 refill hit");
        configure(8'h80, 5'd16);
        do_flush();
        expect_walk(8'h80, 4'd3, 3'd5, "R11 new base");
        expect_walk(8'h80, 4'd15, 3'd2, "R11 full length");
    endtask

    task automatic t_counters();
        @(negedge clk);
        check(hit_count == 16'(exp_hits), "R9 hit counter", hit_count, exp_hits);
        check(miss_count == 16'(exp_miss), "R9 miss counter", miss_count, exp_miss);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_hit();
        t_range();
        t_round_robin();
        t_flush_cfg();
        t_counters();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule